// File: doc/BRIEF.md
# Shortest-Path Label Engine

This block finds the single-source shortest paths over a small directed, weighted graph. The host first loads the edge costs into an adjacency memory through a write port. It then issues a start command that names the source node. The engine walks the graph one node at a time. For each node it reads in that node's full row of outgoing edge costs, updates the tentative distance of every node not yet settled, and then settles the closest remaining node. A parallel comparator bank makes that selection in a single cycle.

Each node has one label word. The word holds a settled flag, the node's predecessor on the best path found, and its distance from the source. After the done pulse, the host reads the label words back through a combinational read port. Nodes that cannot be reached from the source stay unsettled and report an infinite distance. The run ends as soon as no reachable node is left unsettled.

Top module: `sp_label_engine`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low. Every label word reads 15'h07FF: unsettled, predecessor 0, distance all ones.
- R2: An adjacency write puts the 8-bit cost of edge i to j at address i*8+j. A cost of 8'hFF means the edge is absent and never shortens any distance. After reset, every edge is absent. Costs 0 to 254 are valid, and path costs up to 7*254 are reported exactly.
- R3: Each label word is laid out as bit 14 = settled, bits 13:11 = predecessor index, bits 10:0 = distance. The word for node `lbl_raddr_i` appears combinationally on `lbl_rdata_o`.
- R4: A `start_i` pulse while idle raises `busy_o` on the next cycle. After the run, the source node reads settled, with distance 0 and predecessor equal to itself.
- R5: After a run, every node reachable from the source reads settled, and its distance equals the minimum path cost from the source.
- R6: The predecessor of each reached non-source node is the node whose settling last strictly lowered that node's distance.
- R7: A node that cannot be reached reads unsettled, with distance 11'h7FF and predecessor equal to the source.
- R8: When several unsettled, reachable nodes share the smallest distance, the one with the lowest index is settled first.
- R9: `done_o` is high for exactly one cycle, which is the last cycle that `busy_o` is high.
- R10: While `busy_o` is high, adjacency writes and `start_i` are ignored.
- R11: With N = 8 nodes and r of them reachable (the source included), `busy_o` stays high for exactly r*(N+2)+1 cycles. Unreachable nodes therefore end the run early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adj_we_i | input | 1 | Adjacency write enable |
| adj_waddr_i | input | 6 | Adjacency address, {from, to} |
| adj_wdata_i | input | 8 | Edge cost; 8'hFF means no edge |
| start_i | input | 1 | Start a run |
| src_i | input | 3 | Source node for the run |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| lbl_raddr_i | input | 3 | Label read address |
| lbl_rdata_o | output | 15 | Label word {settled, pred, dist} |

## Verification
Several graphs are used, and each one separates a different behaviour:
- A chain with a costly shortcut shows whether relaxation actually replaces a direct-edge distance with a cheaper multi-hop path.
- A dense graph with scattered missing edges is swept over all eight sources. This covers every starting point and every row of the matrix.
- A graph split into two islands exposes unreachable labels and the shortened run length.
- Two equal-cost diamonds show whether the lowest-index rule decides the predecessor.
- A chain of 254-cost edges probes the widest distance.

Writes and starts issued during a run are followed by a rerun on the same source, so that a write which leaked into the matrix shows up in the results.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RELAX,
    ST_SELECT,
    ST_DONE
  } sp_state_e;

  // Distance width: one code above the longest possible path is kept as infinity.
  function automatic int dist_width(input int n, input int cw);
    return $clog2((n - 1) * ((1 << cw) - 1) + 2);
  endfunction
endpackage

// File: rtl/sp_adj_mem.sv
module sp_adj_mem #(
  parameter int N_NODES = 8,
  parameter int COST_W  = 8,
  localparam int IDX_W  = $clog2(N_NODES),
  localparam int ADDR_W = 2 * IDX_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [COST_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [COST_W-1:0] rdata_o
);
  logic [DEPTH-1:0][COST_W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '1;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sp_min_select.sv
module sp_min_select #(
  parameter int N_NODES = 8,
  parameter int DIST_W  = 11,
  localparam int IDX_W  = $clog2(N_NODES)
) (
  input  logic [N_NODES-1:0][DIST_W-1:0] dist_i,
  input  logic [N_NODES-1:0]             elig_i,
  output logic                           valid_o,
  output logic [IDX_W-1:0]               idx_o,
  output logic [DIST_W-1:0]              min_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    min_o   = '1;
    // strict compare keeps the lowest index on ties
    for (int j = 0; j < N_NODES; j++) begin
      if (elig_i[j] && (!valid_o || dist_i[j] < min_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(j);
        min_o   = dist_i[j];
      end
    end
  end
endmodule

// File: rtl/sp_label_file.sv
module sp_label_file #(
  parameter int N_NODES = 8,
  parameter int COST_W  = 8,
  parameter int DIST_W  = 11,
  localparam int IDX_W  = $clog2(N_NODES),
  localparam int LBL_W  = 1 + IDX_W + DIST_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           init_i,
  input  logic [IDX_W-1:0]               src_i,
  input  logic                           relax_i,
  input  logic [IDX_W-1:0]               cur_i,
  input  logic [N_NODES-1:0][COST_W-1:0] row_i,
  input  logic                           mark_i,
  input  logic [IDX_W-1:0]               mark_idx_i,
  input  logic [IDX_W-1:0]               rd_addr_i,
  output logic [LBL_W-1:0]               rd_data_o,
  output logic [N_NODES-1:0][DIST_W-1:0] dist_o,
  output logic [N_NODES-1:0]             known_o
);
  logic [N_NODES-1:0]             known_q;
  logic [N_NODES-1:0][IDX_W-1:0]  pred_q;
  logic [N_NODES-1:0][DIST_W-1:0] dist_q;
  logic [N_NODES-1:0][DIST_W:0]   cand_w;
  logic [N_NODES-1:0]             upd_w;
  logic [DIST_W-1:0]              cur_dist_w;

  assign cur_dist_w = dist_q[cur_i];

  for (genvar j = 0; j < N_NODES; j++) begin : g_node
    assign cand_w[j] = {1'b0, cur_dist_w} + (DIST_W+1)'(row_i[j]);
    assign upd_w[j]  = !known_q[j] && (row_i[j] != '1) && (cand_w[j] < {1'b0, dist_q[j]});

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        known_q[j] <= 1'b0;
        pred_q[j]  <= '0;
        dist_q[j]  <= '1;
      end else if (init_i) begin
        known_q[j] <= (src_i == IDX_W'(j));
        pred_q[j]  <= src_i;
        dist_q[j]  <= (src_i == IDX_W'(j)) ? '0 : '1;
      end else if (relax_i && upd_w[j]) begin
        pred_q[j]  <= cur_i;
        dist_q[j]  <= cand_w[j][DIST_W-1:0];
      end else if (mark_i && mark_idx_i == IDX_W'(j)) begin
        known_q[j] <= 1'b1;
      end
    end

    assert_known_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!init_i && known_q[j]) |=> known_q[j]);

    assert_dist_monotone_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !init_i |=> dist_q[j] <= $past(dist_q[j]));
  end

  assign rd_data_o = {known_q[rd_addr_i], pred_q[rd_addr_i], dist_q[rd_addr_i]};
  assign dist_o    = dist_q;
  assign known_o   = known_q;
endmodule

// File: rtl/sp_label_engine.sv
module sp_label_engine #(
  parameter int N_NODES = 8,
  parameter int COST_W  = 8,
  localparam int IDX_W  = $clog2(N_NODES),
  localparam int ADDR_W = 2 * IDX_W,
  localparam int DIST_W = sp_pkg::dist_width(N_NODES, COST_W),
  localparam int LBL_W  = 1 + IDX_W + DIST_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adj_we_i,
  input  logic [ADDR_W-1:0] adj_waddr_i,
  input  logic [COST_W-1:0] adj_wdata_i,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  src_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic [IDX_W-1:0]  lbl_raddr_i,
  output logic [LBL_W-1:0]  lbl_rdata_o
);
  import sp_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_NODES - 1);

  sp_state_e                      state_q;
  logic [IDX_W-1:0]               cur_q;
  logic [IDX_W-1:0]               cnt_q;
  logic [N_NODES-1:0][COST_W-1:0] row_q;
  logic [COST_W-1:0]              adj_rdata_w;
  logic [N_NODES-1:0][DIST_W-1:0] dist_w;
  logic [N_NODES-1:0]             known_w;
  logic [N_NODES-1:0]             elig_w;
  logic                           sel_valid_w;
  logic [IDX_W-1:0]               sel_idx_w;
  logic [DIST_W-1:0]              sel_min_w;
  logic                           idle_w;

  assign idle_w = (state_q == ST_IDLE);

  sp_adj_mem #(.N_NODES(N_NODES), .COST_W(COST_W)) u_adj (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (adj_we_i && idle_w),
    .waddr_i (adj_waddr_i),
    .wdata_i (adj_wdata_i),
    .raddr_i ({cur_q, cnt_q}),
    .rdata_o (adj_rdata_w)
  );

  sp_label_file #(.N_NODES(N_NODES), .COST_W(COST_W), .DIST_W(DIST_W)) u_lbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (idle_w && start_i),
    .src_i      (src_i),
    .relax_i    (state_q == ST_RELAX),
    .cur_i      (cur_q),
    .row_i      (row_q),
    .mark_i     ((state_q == ST_SELECT) && sel_valid_w),
    .mark_idx_i (sel_idx_w),
    .rd_addr_i  (lbl_raddr_i),
    .rd_data_o  (lbl_rdata_o),
    .dist_o     (dist_w),
    .known_o    (known_w)
  );

  for (genvar j = 0; j < N_NODES; j++) begin : g_elig
    assign elig_w[j] = !known_w[j] && (dist_w[j] != '1);

    assert_sel_min_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_valid_w && elig_w[j]) |-> sel_min_w <= dist_w[j]);

    assert_sel_tie_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_valid_w && elig_w[j] && dist_w[j] == sel_min_w) |-> sel_idx_w <= IDX_W'(j));
  end

  sp_min_select #(.N_NODES(N_NODES), .DIST_W(DIST_W)) u_min (
    .dist_i  (dist_w),
    .elig_i  (elig_w),
    .valid_o (sel_valid_w),
    .idx_o   (sel_idx_w),
    .min_o   (sel_min_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      cnt_q   <= '0;
      row_q   <= '1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cur_q   <= src_i;
          cnt_q   <= '0;
          state_q <= ST_FETCH;
        end
        ST_FETCH: begin
          row_q[cnt_q] <= adj_rdata_w;
          if (cnt_q == LAST_IDX) begin
            cnt_q   <= '0;
            state_q <= ST_RELAX;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RELAX: state_q <= ST_SELECT;
        ST_SELECT: begin
          if (sel_valid_w) begin
            cur_q   <= sel_idx_w;
            state_q <= ST_FETCH;
          end else begin
            state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = !idle_w;
  assign done_o = (state_q == ST_DONE);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  assert_start_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  assert_done_has_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
endmodule

// File: tb/sp_label_engine_tb.sv
module sp_label_engine_tb;
  localparam int N = 8;
  localparam int INF = 2047;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adj_we = 1'b0;
  logic [5:0] adj_waddr = '0;
  logic [7:0] adj_wdata = '0;
  logic start = 1'b0;
  logic [2:0] src = '0;
  logic busy, done;
  logic [2:0] lbl_raddr = '0;
  logic [14:0] lbl_rdata;

  int n_checks = 0;
  int n_fail = 0;
  int adj [64];
  int e_dist [N];
  int e_pred [N];
  int e_known [N];
  int e_reach;

  always #10 clk = ~clk;

  sp_label_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .adj_we_i(adj_we), .adj_waddr_i(adj_waddr), .adj_wdata_i(adj_wdata),
    .start_i(start), .src_i(src), .busy_o(busy), .done_o(done),
    .lbl_raddr_i(lbl_raddr), .lbl_rdata_o(lbl_rdata)
  );

  task automatic check(input int act, input int exp, input string tag);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load_graph();
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      adj_we = 1'b1; adj_waddr = 6'(a); adj_wdata = 8'(adj[a]);
    end
    @(negedge clk);
    adj_we = 1'b0;
  endtask

  // Expected labels from the requirements
  task automatic model(input int s);
    int cur, best, bi;
    for (int j = 0; j < N; j++) begin
      e_dist[j] = INF; e_pred[j] = s; e_known[j] = 0;
    end
    e_dist[s] = 0; e_known[s] = 1; cur = s; e_reach = 1;
    forever begin
      for (int j = 0; j < N; j++) begin
        int c = adj[cur*8+j];
        if (!e_known[j] && c != 255 && e_dist[cur] + c < e_dist[j]) begin
          e_dist[j] = e_dist[cur] + c; e_pred[j] = cur;
        end
      end
      bi = -1; best = INF;
      for (int j = 0; j < N; j++)
        if (!e_known[j] && e_dist[j] != INF && (bi < 0 || e_dist[j] < best)) begin
          bi = j; best = e_dist[j];
        end
      if (bi < 0) break;
      e_known[bi] = 1; cur = bi; e_reach++;
    end
  endtask

  task automatic run(input int s, input bit disturb, input string tag);
    int cyc = 0, dones = 0, done_last = 0;
    model(s);
    @(negedge clk);
    start = 1'b1; src = 3'(s);
    @(negedge clk);
    start = 1'b0;
    while (busy && cyc < 2000) begin
      cyc++;
      done_last = done;
      if (done) dones++;
      if (disturb && cyc == 5) begin
        adj_we = 1'b1; adj_waddr = 6'(s*8 + ((s+1)%N)); adj_wdata = 8'd0;
        start = 1'b1; src = 3'((s+3)%N);
      end else begin
        adj_we = 1'b0; start = 1'b0;
      end
      @(negedge clk);
    end
    adj_we = 1'b0; start = 1'b0;
    check(cyc, e_reach*(N+2)+1, {tag, " R11 busy cycles"});
    check(dones, 1, {tag, " R9 done count"});
    check(done_last, 1, {tag, " R9 done on last busy cycle"});
    for (int j = 0; j < N; j++) begin
      lbl_raddr = 3'(j);
      #1;
      if (e_known[j]) begin
        check(int'(lbl_rdata[10:0]), e_dist[j], $sformatf("%s R5 dist node %0d", tag, j));
        check(int'(lbl_rdata[13:11]), e_pred[j], $sformatf("%s R6 pred node %0d", tag, j));
        check(int'(lbl_rdata[14]), 1, $sformatf("%s R5 settled node %0d", tag, j));
      end else begin
        check(int'(lbl_rdata), (s << 11) | INF, $sformatf("%s R7 unreachable node %0d", tag, j));
      end
    end
    lbl_raddr = 3'(s);
    #1;
    check(int'(lbl_rdata), (1 << 14) | (s << 11), {tag, " R3 R4 source word"});
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(int'(busy), 0, "R1 busy after reset");
    check(int'(done), 0, "R1 done after reset");
    for (int j = 0; j < N; j++) begin
      lbl_raddr = 3'(j);
      #1;
      check(int'(lbl_rdata), 15'h07FF, $sformatf("R1 label %0d after reset", j));
    end
    // R2: empty matrix after reset -> only source reached
    for (int a = 0; a < 64; a++) adj[a] = 255;
    run(4, 1'b0, "R2 empty");

    // chain with costly shortcut
    for (int a = 0; a < 64; a++) adj[a] = 255;
    for (int i = 0; i < N-1; i++) adj[i*8+i+1] = 10 + i;
    adj[0*8+7] = 200;
    load_graph();
    run(0, 1'b0, "chain");
    run(3, 1'b0, "chain");

    // dense graph swept over all sources
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        adj[i*8+j] = ((i + 2*j) % 5 == 0) ? 255 : ((i*37 + j*19 + 5) % 97) + 1;
    load_graph();
    for (int s = 0; s < N; s++) run(s, 1'b0, "dense");

    // R10: writes and starts during a run are ignored; rerun proves matrix intact
    run(2, 1'b1, "R10 disturbed");
    run(2, 1'b0, "R10 rerun");

    // two islands
    for (int a = 0; a < 64; a++) adj[a] = 255;
    adj[0*8+1] = 3; adj[1*8+2] = 4; adj[2*8+3] = 5; adj[3*8+0] = 1;
    adj[4*8+5] = 1; adj[5*8+6] = 1; adj[6*8+7] = 1; adj[7*8+4] = 1;
    load_graph();
    run(0, 1'b0, "R7 islands");
    run(6, 1'b0, "R7 islands");

    // equal-cost diamonds: R8 lowest index settles first
    for (int a = 0; a < 64; a++) adj[a] = 255;
    adj[0*8+1] = 5; adj[0*8+2] = 5; adj[1*8+3] = 5; adj[2*8+3] = 5;
    adj[3*8+5] = 7; adj[3*8+4] = 7; adj[4*8+6] = 2; adj[5*8+6] = 2;
    load_graph();
    run(0, 1'b0, "R8 tie");
    lbl_raddr = 3'd3; #1;
    check(int'(lbl_rdata[13:11]), 1, "R8 node 3 pred lower index");
    lbl_raddr = 3'd6; #1;
    check(int'(lbl_rdata[13:11]), 4, "R8 node 6 pred lower index");

    // widest distance: chain of 254 costs
    for (int a = 0; a < 64; a++) adj[a] = 255;
    for (int i = 0; i < N-1; i++) adj[i*8+i+1] = 254;
    load_graph();
    run(0, 1'b0, "R2 max chain");
    lbl_raddr = 3'd7; #1;
    check(int'(lbl_rdata[10:0]), 7*254, "R2 max distance");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule